// File: doc/BRIEF.md
# Pipelined Binary-to-Residue Converter

The block takes an unsigned binary word and produces its residue for each modulus in a fixed set. Each modulus has its own converter chain. The chain reads the word from the most significant end, one bit group at a time. Every stage of the chain is a small lookup table. Its address is the partial remainder from the stage before it, with the next group of input bits appended. The stage stores the new partial remainder in a pipeline register. The partial remainder needs only ceil(log2 m) bits, because it can take at most m distinct values. The table in the last stage of the chain produces the residue itself.

Every table entry is computed from its own address at elaboration: entry e holds e mod m. Stage 0 consumes STAGE_W bits. Each later stage consumes STAGE_W - r bits, where r is the partial-remainder width, so that its address stays at STAGE_W bits. A chain therefore needs the smallest s with STAGE_W + (s-1)(STAGE_W - r) >= DATA_W. Chains with fewer stages are padded with delay registers, so that every residue comes out in the same cycle. The block accepts one word per cycle and has a fixed latency. Results are packed into one output vector, one RES_W-bit field per modulus.

Top module: `b2r_cascade_conv`

## Requirements
- R1: When valid_o is high, field i of residue_o (bits i*RES_W upward) equals the input word mod MODULI[i]. With the defaults (16-bit input, moduli 3, 7, 11, 13, RES_W 4), field 0 is mod 3, field 1 is mod 7, field 2 is mod 11 and field 3 is mod 13.
- R2: valid_o rises exactly LAT cycles after the clock edge that samples a high valid_i. LAT is the largest stage count among the chains, which is 6 with the defaults. valid_o is never high without a matching earlier input.
- R3: Inputs presented on consecutive cycles produce results on consecutive cycles, in the same order.
- R4: While valid_o is low, residue_o keeps the last valid result. After reset, that value is zero.
- R5: The boundary words are converted correctly: 0, the all-ones word, the product of all moduli (every residue 0), and that product minus 1 (every residue m_i - 1).
- R6: During reset, valid_o is low and residue_o is all zeros.
- R7: Field bits above a chain's remainder width always read zero. For modulus 3, bits 3:2 of field 0 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input word is valid |
| data_i | input | DATA_W | Unsigned binary word |
| valid_o | output | 1 | Residue tuple is valid |
| residue_o | output | NUM_MOD*RES_W | Packed residues, field i for MODULI[i] |

## Verification
The hardest case to reach is a mix of gaps and back-to-back words. In that case the chains of different depths and their padding registers must keep the same words aligned, while each held output keeps its old value. The stimulus reaches it in stages. First come directed boundary words separated by idle cycles. Then comes an unbroken burst of random words. Last comes a random stream in which valid_i is high on about half of the cycles. Every cycle is compared against a reference queue that is delayed by the latency. In that reference, the hold value is carried forward whenever no result is expected.

// File: rtl/b2r_pkg.sv
package b2r_pkg;

  function automatic int unsigned clog2u(input int unsigned v);
    int unsigned r;
    r = 0;
    while ((32'd1 << r) < v) r++;
    return (r == 0) ? 1 : r;
  endfunction

  // stages needed: k + (s-1)(k-r) >= n
  function automatic int unsigned stage_cnt(input int unsigned n, input int unsigned k,
                                            input int unsigned r);
    if (n <= k) return 1;
    return 1 + (n - k + (k - r) - 1) / (k - r);
  endfunction

  function automatic int unsigned consumed_before(input int unsigned n, input int unsigned k,
                                                  input int unsigned r, input int unsigned j);
    int unsigned first;
    first = (n < k) ? n : k;
    if (j == 0) return 0;
    return first + (j - 1) * (k - r);
  endfunction

  function automatic int unsigned grp_w(input int unsigned n, input int unsigned k,
                                        input int unsigned r, input int unsigned j);
    int unsigned left;
    if (j == 0) return (n < k) ? n : k;
    left = n - consumed_before(n, k, r, j);
    return (left < (k - r)) ? left : (k - r);
  endfunction

endpackage

// File: rtl/b2r_stage.sv
module b2r_stage #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned MOD    = 3,
  parameter int unsigned RAIL_W = 2,
  parameter int unsigned GRP_W  = 4,
  parameter int unsigned LSB    = 0,
  parameter bit          FIRST  = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [RAIL_W-1:0] rail_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic [RAIL_W-1:0] rail_o
);
  localparam int unsigned IDX_W = FIRST ? GRP_W : RAIL_W + GRP_W;
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0]  idx;
  logic [RAIL_W-1:0] tbl [DEPTH];

  // address {rail, bits} equals rail*2^g + bits, so entry e is e mod MOD
  for (genvar e = 0; e < DEPTH; e++) begin : g_tbl
    assign tbl[e] = RAIL_W'(e % MOD);
  end

  if (FIRST) begin : g_first
    logic unused_rail;
    assign unused_rail = ^rail_i;
    assign idx = data_i[LSB +: GRP_W];
  end else begin : g_next
    assign idx = {rail_i, data_i[LSB +: GRP_W]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      rail_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        data_o <= data_i;
        rail_o <= tbl[idx];
      end
    end
  end

  // R1
  rail_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (32'(rail_o) < MOD));

endmodule

// File: rtl/b2r_hold_pipe.sv
module b2r_hold_pipe #(
  parameter int unsigned DEPTH = 1,
  parameter int unsigned W     = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  if (DEPTH == 0) begin : g_pass
    assign valid_o = valid_i;
    assign data_o  = data_i;
  end else begin : g_regs
    logic         v_q [DEPTH];
    logic [W-1:0] d_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) begin
          v_q[i] <= 1'b0;
          d_q[i] <= '0;
        end
      end else begin
        v_q[0] <= valid_i;
        if (valid_i) d_q[0] <= data_i;
        for (int i = 1; i < DEPTH; i++) begin
          v_q[i] <= v_q[i-1];
          if (v_q[i-1]) d_q[i] <= d_q[i-1];
        end
      end
    end

    assign valid_o = v_q[DEPTH-1];
    assign data_o  = d_q[DEPTH-1];
  end
endmodule

// File: rtl/b2r_lane.sv
module b2r_lane #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned STAGE_W = 6,
  parameter int unsigned MOD     = 3,
  parameter int unsigned LAT     = 6,
  parameter int unsigned RES_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [RES_W-1:0]  res_o
);
  localparam int unsigned RAIL_W = b2r_pkg::clog2u(MOD);
  localparam int unsigned S      = b2r_pkg::stage_cnt(DATA_W, STAGE_W, RAIL_W);
  localparam int unsigned PAD    = LAT - S;

  logic              v  [S+1];
  logic [DATA_W-1:0] d  [S+1];
  logic [RAIL_W-1:0] rl [S+1];
  logic [RAIL_W-1:0] rail_out;
  logic              unused_data;

  assign v[0]  = valid_i;
  assign d[0]  = data_i;
  assign rl[0] = '0;

  for (genvar j = 0; j < S; j++) begin : g_stage
    localparam int unsigned G   = b2r_pkg::grp_w(DATA_W, STAGE_W, RAIL_W, j);
    localparam int unsigned LSB = DATA_W - b2r_pkg::consumed_before(DATA_W, STAGE_W, RAIL_W, j) - G;
    b2r_stage #(
      .DATA_W(DATA_W), .MOD(MOD), .RAIL_W(RAIL_W),
      .GRP_W(G), .LSB(LSB), .FIRST(j == 0)
    ) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(v[j]),
      .data_i (d[j]),
      .rail_i (rl[j]),
      .valid_o(v[j+1]),
      .data_o (d[j+1]),
      .rail_o (rl[j+1])
    );
  end

  assign unused_data = ^d[S];

  b2r_hold_pipe #(.DEPTH(PAD), .W(RAIL_W)) u_pad (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(v[S]),
    .data_i (rl[S]),
    .valid_o(valid_o),
    .data_o (rail_out)
  );

  assign res_o = RES_W'(rail_out);

  // R1
  res_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (32'(res_o) < MOD));

  // R4
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(res_o));

endmodule

// File: rtl/b2r_cascade_conv.sv
module b2r_cascade_conv #(
  parameter int unsigned DATA_W           = 16,
  parameter int unsigned STAGE_W          = 6,
  parameter int unsigned NUM_MOD          = 4,
  parameter int unsigned MODULI [NUM_MOD] = '{3, 7, 11, 13},
  parameter int unsigned RES_W            = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [DATA_W-1:0]        data_i,
  output logic                     valid_o,
  output logic [NUM_MOD*RES_W-1:0] residue_o
);
  function automatic int unsigned worst_lat();
    int unsigned w;
    w = 0;
    for (int i = 0; i < NUM_MOD; i++) begin
      int unsigned s;
      s = b2r_pkg::stage_cnt(DATA_W, STAGE_W, b2r_pkg::clog2u(MODULI[i]));
      if (s > w) w = s;
    end
    return w;
  endfunction

  localparam int unsigned LAT   = worst_lat();
  localparam int unsigned CNT_W = $clog2(LAT + 2);

  logic [NUM_MOD-1:0] lane_v;

  for (genvar i = 0; i < NUM_MOD; i++) begin : g_lane
    b2r_lane #(
      .DATA_W(DATA_W), .STAGE_W(STAGE_W), .MOD(MODULI[i]),
      .LAT(LAT), .RES_W(RES_W)
    ) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(valid_i),
      .data_i (data_i),
      .valid_o(lane_v[i]),
      .res_o  (residue_o[i*RES_W +: RES_W])
    );
  end

  assign valid_o = lane_v[0];

  // words in flight, for the checks below only
  logic [CNT_W-1:0] inflight_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inflight_q <= '0;
    else         inflight_q <= inflight_q + CNT_W'(valid_i) - CNT_W'(valid_o);
  end

  // R2
  lane_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_v == '0) || (lane_v == '1));

  // R2
  inflight_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(inflight_q) <= LAT);

  // R2
  no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (inflight_q != '0));

endmodule

// File: tb/b2r_cascade_conv_bench.sv
module b2r_cascade_conv_bench;
  localparam int unsigned DW  = 16;
  localparam int unsigned NM  = 4;
  localparam int unsigned RW  = 4;
  localparam int unsigned LAT = 6;
  localparam int unsigned MODS [NM] = '{3, 7, 11, 13};

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               valid_in = 1'b0;
  logic [DW-1:0]      data_in = '0;
  logic               valid_out;
  logic [NM*RW-1:0]   res_out;

  int checks = 0;
  int fails  = 0;
  int n_step = 0;
  bit done   = 1'b0;

  bit               rv [16];
  logic [DW-1:0]    rx [16];
  string            rt [16];
  logic [NM*RW-1:0] last_res = '0;

  always #10 clk = ~clk;

  b2r_cascade_conv u_b2r_cascade_conv (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .valid_i  (valid_in),
    .data_i   (data_in),
    .valid_o  (valid_out),
    .residue_o(res_out)
  );

  function automatic logic [NM*RW-1:0] exp_res(input logic [DW-1:0] x);
    logic [NM*RW-1:0] r;
    r = '0;
    for (int i = 0; i < NM; i++) r[i*RW +: RW] = RW'(int'(x) % MODS[i]);
    return r;
  endfunction

  task automatic check(input string tag, input logic [NM*RW-1:0] act,
                       input logic [NM*RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s step %0d: actual %h expected %h", tag, n_step, act, exp);
    end
  endtask

  // sample outputs, then drive the next input
  task automatic step(input bit v, input logic [DW-1:0] x, input string tag);
    bit ev;
    ev = (n_step >= LAT) ? rv[(n_step - LAT) % 16] : 1'b0;
    check("R2", NM*RW'(valid_out), NM*RW'(ev));
    if (ev) begin
      last_res = exp_res(rx[(n_step - LAT) % 16]);
      check(rt[(n_step - LAT) % 16], res_out, last_res);
      check("R7", NM*RW'(res_out[3:2]), '0);
    end else begin
      check("R4", res_out, last_res);
    end
    rv[n_step % 16] = v;
    rx[n_step % 16] = x;
    rt[n_step % 16] = tag;
    valid_in = v;
    data_in  = x;
    n_step++;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R6
    check("R6", NM*RW'(valid_out), '0);
    check("R6", res_out, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 boundary words separated by gaps
    step(1'b1, 16'd0,     "R5");
    step(1'b0, 16'd0,     "R4");
    step(1'b1, 16'hFFFF,  "R5");
    step(1'b0, 16'h1234,  "R4");
    step(1'b0, 16'h0,     "R4");
    step(1'b1, 16'd3003,  "R5");
    step(1'b1, 16'd3002,  "R5");
    step(1'b0, 16'hAAAA,  "R4");
    step(1'b1, 16'd6006,  "R5");
    step(1'b1, 16'd1,     "R5");
    for (int i = 0; i < 8; i++) step(1'b0, 16'(i * 977), "R4");

    // R3 unbroken burst
    for (int i = 0; i < 48; i++) step(1'b1, 16'($urandom), "R3");
    // R1 random stream with gaps
    for (int i = 0; i < 400; i++) step(($urandom % 2) == 0, 16'($urandom), "R1");
    for (int i = 0; i < LAT + 4; i++) step(1'b0, '0, "R4");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule